// File: doc/BRIEF.md
# Prescaled Pulse Width Modulator

This block produces one pulse width modulated output from a single clock. A prescaler turns the input clock into a tick enable. A period counter advances once per tick and wraps after a programmed number of ticks. A duty compare holds the output high for the first part of each cycle and low for the rest. Software sets the block up through a plain write strobe, a 2-bit register select and a data word. There are three settings: prescale, period, and duty with a full-duty flag.

Period and duty settings are copied into shadow registers only when a cycle ends, so a write never shortens or distorts the cycle in progress. A zero period and a zero duty each have a defined output level. The full-duty flag overrides the compare.

Top module: `pwm_gen`

## Requirements
- R1: After reset the output is low, the period setting is 4 and every other setting is 0. Writing only a duty of 2 then gives cycles of 5 ticks, each with 2 ticks high.
- R2: With a nonzero period value P, one output cycle lasts P + 1 ticks. For example, P = 10 gives 11 ticks.
- R3: With period P > 0, full-duty flag clear and 0 < duty D <= P, the output is high for D ticks and low for P + 1 - D ticks in each cycle. For example, P = 10 and D = 6 give 6 ticks high and 5 ticks low.
- R4: A tick occurs on every clock when prescale S = 0. Otherwise a tick occurs once every S + 1 clocks. The prescale count wraps to 0 on the clock where it is greater than or equal to S. A new S therefore takes effect at once and never makes the count wrap around its full range.
- R5: When the full-duty flag (data bit 10 of a duty write) is set, the output stays high, whatever the duty and period values.
- R6: A period value of 0 holds the output high without toggling, as long as the duty or the full-duty flag is nonzero.
- R7: A period value of 0 together with a duty of 0 and a clear full-duty flag holds the output low without toggling.
- R8: With the full-duty flag clear, a duty of 0 holds the output low. A duty of P + 1 or more holds it continuously high.
- R9: Period and duty writes made in the middle of a cycle take effect only when the next cycle starts.
- R10: Each cycle starts with the counter at 0 and the output high, whenever the duty is nonzero. The output falls when the counter reaches the duty value.
- R11: Register select values are 0 = prescale (data bits 5:0), 1 = period (data bits 9:0) and 2 = duty (data bits 9:0, full-duty flag in bit 10). A write with select 3 changes nothing.
- R12: The output is registered and changes only on a clock edge. Its level always matches the counter and shadow settings in use for that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one clock per write |
| wr_sel_i | input | 2 | Register select: 0 prescale, 1 period, 2 duty/full flag, 3 unused |
| wr_data_i | input | WR_W (16) | Write data |
| pwm_o | output | 1 | Modulated output |

## Verification
The bench uses the default widths: a 6-bit prescale, a 10-bit period and duty, and a period reset value of 4. The 10-bit duty lets the bench write values far above the period, which tests the saturation rule. It runs prescale values between 0 and 5, so divided cycles stay short enough to measure many of them exactly. A prescale lowered below the running count tests the no-wraparound rule. Zero period, zero duty, a full-duty override and writes landing mid-cycle are each compared clock by clock against a behavioural model. Run lengths of high and low stretches are also measured directly.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    SEL_PRESCALE = 2'd0,
    SEL_PERIOD   = 2'd1,
    SEL_DUTY     = 2'd2,
    SEL_NONE     = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int PRE_W   = 6,
  parameter int PER_W   = 10,
  parameter int PER_RST = 4,
  parameter int WR_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [WR_W-1:0]  wr_data_i,
  output logic [PRE_W-1:0] prescale_o,
  output logic [PER_W-1:0] period_o,
  output logic [PER_W-1:0] duty_o,
  output logic             full_o
);
  import pwm_pkg::*;

  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prescale_o <= '0;
      period_o   <= PER_W'(PER_RST);
      duty_o     <= '0;
      full_o     <= 1'b0;
    end else if (wr_en_i) begin
      case (sel)
        SEL_PRESCALE: prescale_o <= wr_data_i[PRE_W-1:0];
        SEL_PERIOD:   period_o   <= wr_data_i[PER_W-1:0];
        SEL_DUTY: begin
          duty_o <= wr_data_i[PER_W-1:0];
          full_o <= wr_data_i[PER_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] prescale_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;

  // >= so a lowered prescale wraps at once instead of rolling over
  assign tick_o = (cnt_q >= prescale_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + PRE_W'(1);
  end
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int PER_W   = 10,
  parameter int PER_RST = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [PER_W-1:0] duty_i,
  input  logic             full_i,
  output logic [PER_W-1:0] cnt_o,
  output logic [PER_W-1:0] per_s_o,
  output logic [PER_W-1:0] duty_s_o,
  output logic             full_s_o,
  output logic             pwm_o
);
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [PER_W-1:0] duty_q, duty_d;
  logic             full_q, full_d;
  logic             cyc_end;
  logic             lvl_d;

  assign cyc_end = tick_i && (cnt_q >= per_q);

  always_comb begin
    cnt_d  = cnt_q;
    per_d  = per_q;
    duty_d = duty_q;
    full_d = full_q;
    if (cyc_end) begin
      cnt_d  = '0;
      per_d  = period_i;
      duty_d = duty_i;
      full_d = full_i;
    end else if (tick_i) begin
      cnt_d  = cnt_q + PER_W'(1);
    end
  end

  // output level from next state so pwm_o lines up with cnt_q
  always_comb begin
    if (full_d)             lvl_d = 1'b1;
    else if (per_d == '0)   lvl_d = (duty_d != '0);
    else                    lvl_d = (cnt_d < duty_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      per_q  <= PER_W'(PER_RST);
      duty_q <= '0;
      full_q <= 1'b0;
      pwm_o  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      duty_q <= duty_d;
      full_q <= full_d;
      pwm_o  <= lvl_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign per_s_o  = per_q;
  assign duty_s_o = duty_q;
  assign full_s_o = full_q;
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen #(
  parameter int PRE_W   = 6,
  parameter int PER_W   = 10,
  parameter int PER_RST = 4,
  parameter int WR_W    = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_sel_i,
  input  logic [WR_W-1:0] wr_data_i,
  output logic            pwm_o
);
  logic [PRE_W-1:0] prescale;
  logic [PER_W-1:0] period, duty;
  logic             full;
  logic             tick;
  logic [PER_W-1:0] cnt, per_s, duty_s;
  logic             full_s;

  pwm_regs #(
    .PRE_W(PRE_W), .PER_W(PER_W), .PER_RST(PER_RST), .WR_W(WR_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .prescale_o (prescale),
    .period_o   (period),
    .duty_o     (duty),
    .full_o     (full)
  );

  pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .prescale_i (prescale),
    .tick_o     (tick)
  );

  pwm_core #(.PER_W(PER_W), .PER_RST(PER_RST)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .period_i (period),
    .duty_i   (duty),
    .full_i   (full),
    .cnt_o    (cnt),
    .per_s_o  (per_s),
    .duty_s_o (duty_s),
    .full_s_o (full_s),
    .pwm_o    (pwm_o)
  );
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int PER_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [PER_W-1:0] cnt_i,
  input logic [PER_W-1:0] per_s_i,
  input logic [PER_W-1:0] duty_s_i,
  input logic             full_s_i,
  input logic             pwm_i
);
  // R2
  cnt_in_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= per_s_i);

  // R4
  cnt_moves_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_i));

  // R9
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && (cnt_i >= per_s_i)) |=>
      ($stable(per_s_i) && $stable(duty_s_i) && $stable(full_s_i)));

  // R5
  full_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_s_i |-> pwm_i);

  // R7
  zero_zero_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_s_i == '0 && duty_s_i == '0 && !full_s_i) |-> !pwm_i);

  // R6
  zero_per_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_s_i == '0 && duty_s_i != '0) |-> pwm_i);

  // R10
  cycle_start_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0 && duty_s_i != '0) |-> pwm_i);

  // R3
  past_duty_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_s_i && per_s_i != '0 && cnt_i >= duty_s_i) |-> !pwm_i);
endmodule

bind pwm_gen pwm_gen_chk #(.PER_W(PER_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick),
  .cnt_i    (cnt),
  .per_s_i  (per_s),
  .duty_s_i (duty_s),
  .full_s_i (full_s),
  .pwm_i    (pwm_o)
);

// File: tb/tb_pwm_gen.sv
`timescale 1ns/1ps
module tb_pwm_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = 2'd0;
  logic [15:0] wr_data_i = '0;
  logic        pwm_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur = "R1";

  always #10 clk_i = ~clk_i;

  pwm_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .pwm_o(pwm_o)
  );

  // behavioural reference
  int m_pre, m_per, m_duty, m_full;
  int m_pc, m_cnt, s_per, s_duty, s_full;
  bit m_out;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pre = 0; m_per = 4; m_duty = 0; m_full = 0;
      m_pc = 0; m_cnt = 0; s_per = 4; s_duty = 0; s_full = 0;
      m_out = 1'b0;
    end else begin
      if (m_pc >= m_pre) begin
        m_pc = 0;
        if (m_cnt >= s_per) begin
          m_cnt = 0; s_per = m_per; s_duty = m_duty; s_full = m_full;
        end else m_cnt++;
      end else m_pc++;
      if (wr_en_i) begin
        if (wr_sel_i == 2'd0) m_pre = int'(wr_data_i[5:0]);
        else if (wr_sel_i == 2'd1) m_per = int'(wr_data_i[9:0]);
        else if (wr_sel_i == 2'd2) begin
          m_duty = int'(wr_data_i[9:0]);
          m_full = int'(wr_data_i[10]);
        end
      end
      if (s_full != 0) m_out = 1'b1;
      else if (s_per == 0) m_out = (s_duty != 0);
      else m_out = (m_cnt < s_duty);
    end
  end

  // R12: clock-by-clock comparison
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      checks++;
      if (pwm_o !== m_out) begin
        fails++;
        $display("FAIL %s t=%0t pwm_o actual=%0b expected=%0b", cur, $time, pwm_o, m_out);
      end
    end
  end

  // run-length capture
  int run_h = 0, run_l = 0;
  int hq[$];
  int lq[$];
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (pwm_o === 1'b1) begin
        run_h++;
        if (run_l > 0) begin lq.push_back(run_l); run_l = 0; end
      end else begin
        run_l++;
        if (run_h > 0) begin hq.push_back(run_h); run_h = 0; end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (pwm_o === 1'b1) h++;
    end
  endtask

  task automatic sync_high_clear();
    @(negedge clk_i);
    while (pwm_o !== 1'b1) @(negedge clk_i);
    #1;
    hq.delete(); lq.delete();
  endtask

  task automatic check_runs(input string req, input int hi, input int lo);
    if (hq.size() > 1) chk(req, hq[1], hi);
    else chk(req, hq.size(), 2);
    if (lq.size() > 0) chk(req, lq[0], lo);
    else chk(req, lq.size(), 1);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int h;
    idle(3);
    chk("R1 in reset", int'(pwm_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset", int'(pwm_o), 0);

    cur = "R1";
    wr(2'd2, 16'd2);
    idle(20);
    count_high(50, h); chk("R1 reset period", h, 20);

    cur = "R3";
    wr(2'd1, 16'd10); wr(2'd2, 16'd6);
    idle(30);
    count_high(110, h); chk("R3 duty ratio", h, 60);
    sync_high_clear(); idle(40);
    check_runs("R2/R3 runs", 6, 5);

    cur = "R4";
    wr(2'd0, 16'd2);
    idle(100);
    count_high(330, h); chk("R4 prescale 2", h, 180);
    sync_high_clear(); idle(80);
    check_runs("R4 runs", 18, 15);
    wr(2'd0, 16'd5); idle(4); wr(2'd0, 16'd1); idle(60);
    wr(2'd0, 16'd0); idle(40);

    cur = "R9";
    wr(2'd1, 16'd9); wr(2'd2, 16'd5);
    idle(40);
    sync_high_clear();
    wr(2'd1, 16'd3); wr(2'd2, 16'd1);
    idle(30);
    if (hq.size() > 1) begin
      chk("R9 old cycle kept", hq[0], 5);
      chk("R9 new cycle", hq[1], 1);
    end else chk("R9 runs", hq.size(), 2);

    cur = "R10";
    wr(2'd1, 16'd4);
    idle(20);
    sync_high_clear(); idle(30);
    check_runs("R10 start high", 1, 4);

    cur = "R8";
    wr(2'd1, 16'd5); wr(2'd2, 16'd0);
    idle(20);
    count_high(30, h); chk("R8 zero duty", h, 0);
    wr(2'd2, 16'd6); idle(20);
    count_high(30, h); chk("R8 duty=P+1", h, 30);
    wr(2'd2, 16'd1023); idle(20);
    count_high(30, h); chk("R8 duty max", h, 30);

    cur = "R5";
    wr(2'd2, 16'h0402); wr(2'd1, 16'd7); idle(20);
    count_high(30, h); chk("R5 full flag", h, 30);

    cur = "R6";
    wr(2'd1, 16'd0); wr(2'd2, 16'd3); idle(20);
    count_high(30, h); chk("R6 zero period", h, 30);
    wr(2'd2, 16'h0400); idle(10);
    count_high(30, h); chk("R6 zero period full", h, 30);

    cur = "R7";
    wr(2'd2, 16'h0000); idle(10);
    count_high(30, h); chk("R7 all zero", h, 0);

    cur = "R11";
    wr(2'd1, 16'd10); wr(2'd2, 16'd6); idle(30);
    wr(2'd3, 16'hFFFF); idle(5);
    count_high(110, h); chk("R11 unused select", h, 60);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule